// File: doc/BRIEF.md
# PTP Receive Timestamp Capture Filter

This block sits beside a receive MAC and inspects each incoming Ethernet frame as a byte stream. It decides whether the frame is a precision-time-protocol message that must be timestamped. When the frame qualifies, the block keeps the system time that was current when the frame's first byte arrived. It places that value in a 64-bit holding register and flags the frame as timestamped in a per-frame status word.

Software picks what qualifies through a mode field and a message-type configuration register. Five modes are available: layer-2 transport with version 2, UDP transport with version 1, either transport with version 2, every frame regardless of content, and any version-2 event message on either transport. There is a single holding register. After a capture it stays locked until software reads its upper 32 bits, and no other frame can be stamped while it is locked. The lower half must therefore be read before the upper half.

Frames are assumed to start at the destination address. The layer-4 path expects an IPv4 header with no options and no VLAN tag.

Top module: `ptp_rx_stamp`

## Requirements
- R1: After reset, the capture-valid flag, the enable bit, the mode, the configuration, the holding register and the status outputs are all zero.
- R2: Register addresses are 0 for control, 1 for configuration, 2 for the low stamp word and 3 for the high stamp word. Control bit 0 is a read-only valid flag, bits 3:1 are the mode and bit 4 is the capture enable. A write to bit 0 has no effect. Configuration bits 7:0 hold the version-1 message code and bits 15:8 the version-2 message type.
- R3: In mode 000, a frame matches when bytes 12-13 carry Ethertype 0x88F7, the low nibble of byte 15 is 2, and the low nibble of byte 14, zero-extended, equals configuration bits 15:8.
- R4: In mode 001, a frame matches when all of these hold: Ethertype 0x0800, byte 14 is 0x45, byte 23 is 0x11, bytes 36-37 carry port 319, bytes 42-43 are 0x0001, and byte 74 equals configuration bits 7:0.
- R5: In mode 010, a version-2 frame on either the layer-2 or the UDP transport matches when its message type equals configuration bits 15:8. For the UDP transport, the type is the low nibble of byte 42 and the version is the low nibble of byte 43.
- R6: In mode 101, any version-2 frame on either transport whose message type is below 4 matches, and the configuration register is ignored.
- R7: In mode 100, every frame is captured but its status bit 16 stays clear. Mode codes 011, 110 and 111 capture nothing.
- R8: The captured value equals the time input as sampled in the cycle the frame's start byte is accepted.
- R9: The status strobe pulses for one cycle on the second clock edge after the end byte is accepted. Status bit 16 is set in that cycle exactly when the frame was stamped in a mode other than 100.
- R10: While the valid flag is set, no frame is captured and the holding register keeps its value. Reading address 2 leaves the flag set; reading address 3 clears it.
- R11: If a high-word read is accepted in the same cycle in which a matching frame is decided, that frame is not stamped and the valid flag ends up clear.
- R12: A frame that ends before the last header byte its match needs is never captured. That byte is 15 for layer-2, 43 for UDP version 2 and 74 for UDP version 1.
- R13: With the enable bit clear, no frame is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A frame byte is present |
| rx_sof | input | 1 | Present byte is the first of its frame |
| rx_eof | input | 1 | Present byte is the last of its frame |
| rx_data | input | 8 | Frame byte |
| time_now | input | 64 | Free-running system time |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 3 releases the lock) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| stat_valid | output | 1 | One-cycle per-frame status strobe |
| stat_word | output | 32 | Per-frame status word, bit 16 set when the frame was stamped |

## Verification
Two functions can land in the same cycle: software releasing the lock by reading the high word, and the capture decision for a frame that has just ended. The bench first leaves a capture pending. It then ends a second matching frame and places the high-word read exactly in that frame's decision cycle. The check requires three things: the second frame carries no status bit, the valid flag reads back clear, and the holding register still has the first frame's time. A third frame afterwards must be stamped normally, which shows the release took effect.

// File: rtl/ptp_rx_pkg.sv
package ptp_rx_pkg;
    localparam int TIME_W = 64;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_LO  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_HI  = 2'd3;

    // control bits
    localparam int CTL_VALID_BIT = 0;
    localparam int CTL_MODE_LSB  = 1;
    localparam int CTL_EN_BIT    = 4;
    localparam int STAT_TS_BIT   = 16;

    typedef enum logic [2:0] {
        MODE_L2_V2  = 3'b000,
        MODE_L4_V1  = 3'b001,
        MODE_ANY_V2 = 3'b010,
        MODE_ALL    = 3'b100,
        MODE_EVT_V2 = 3'b101
    } mode_e;

    // protocol constants
    localparam logic [15:0] ETYPE_PTP  = 16'h88F7;
    localparam logic [15:0] ETYPE_IP4  = 16'h0800;
    localparam logic [7:0]  IP_VIHL    = 8'h45;
    localparam logic [7:0]  IP_UDP     = 8'h11;
    localparam logic [15:0] EVT_PORT   = 16'd319;
    localparam logic [15:0] V1_VERSION = 16'h0001;
    localparam logic [3:0]  V2_VERSION = 4'd2;

    // header bytes kept per frame, by byte offset from the destination address
    localparam int NSLOT = 10;
    localparam int SLOT_OFF [NSLOT] = '{12, 13, 14, 15, 23, 36, 37, 42, 43, 74};
    localparam int SL_ET_HI = 0;
    localparam int SL_ET_LO = 1;
    localparam int SL_B14   = 2;
    localparam int SL_B15   = 3;
    localparam int SL_PROTO = 4;
    localparam int SL_DP_HI = 5;
    localparam int SL_DP_LO = 6;
    localparam int SL_P0    = 7;
    localparam int SL_P1    = 8;
    localparam int SL_V1C   = 9;

    // last byte index each classification needs
    localparam int LAST_L2   = 15;
    localparam int LAST_L4V2 = 43;
    localparam int LAST_L4V1 = 74;

    typedef struct packed {
        logic       l2_v2;
        logic       l4_v2;
        logic       l4_v1;
        logic [3:0] l2_msg;
        logic [3:0] l4_msg;
        logic [7:0] v1_ctrl;
    } frame_cls_t;

    function automatic logic is_event(input logic [3:0] msg);
        return msg[3:2] == 2'b00;
    endfunction
endpackage

// File: rtl/ptp_rx_parser.sv
module ptp_rx_parser
    import ptp_rx_pkg::*;
#(
    parameter int IDX_W = 7  // must cover LAST_L4V1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic [TIME_W-1:0] time_now,
    output frame_cls_t        cls,
    output logic              done,
    output logic [TIME_W-1:0] frame_time
);
    localparam logic [IDX_W-1:0] IDX_SAT = {IDX_W{1'b1}};

    logic [IDX_W-1:0]  cnt_q, cur_idx, last_q;
    logic [TIME_W-1:0] sof_time_q;
    logic [7:0]        slot_q [NSLOT];

    assign cur_idx = rx_sof ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            last_q     <= '0;
            done       <= 1'b0;
            sof_time_q <= '0;
            frame_time <= '0;
        end else begin
            done <= rx_valid && rx_eof;
            if (rx_valid) begin
                cnt_q <= (cur_idx == IDX_SAT) ? cur_idx : cur_idx + 1'b1;
                if (rx_sof) sof_time_q <= time_now;
                if (rx_eof) begin
                    last_q     <= cur_idx;
                    frame_time <= rx_sof ? time_now : sof_time_q;
                end
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (rx_valid && cur_idx == IDX_W'(SLOT_OFF[g]))
                slot_q[g] <= rx_data;
        end
    end

    logic l2_base, l4_base;
    always_comb begin
        l2_base = {slot_q[SL_ET_HI], slot_q[SL_ET_LO]} == ETYPE_PTP &&
                  last_q >= IDX_W'(LAST_L2);
        l4_base = {slot_q[SL_ET_HI], slot_q[SL_ET_LO]} == ETYPE_IP4 &&
                  slot_q[SL_B14] == IP_VIHL && slot_q[SL_PROTO] == IP_UDP &&
                  {slot_q[SL_DP_HI], slot_q[SL_DP_LO]} == EVT_PORT &&
                  last_q >= IDX_W'(LAST_L4V2);
        cls.l2_v2   = l2_base && slot_q[SL_B15][3:0] == V2_VERSION;
        cls.l4_v2   = l4_base && slot_q[SL_P1][3:0] == V2_VERSION;
        cls.l4_v1   = l4_base && last_q >= IDX_W'(LAST_L4V1) &&
                      {slot_q[SL_P0], slot_q[SL_P1]} == V1_VERSION;
        cls.l2_msg  = slot_q[SL_B14][3:0];
        cls.l4_msg  = slot_q[SL_P0][3:0];
        cls.v1_ctrl = slot_q[SL_V1C];
    end
endmodule

// File: rtl/ptp_rx_match.sv
module ptp_rx_match
    import ptp_rx_pkg::*;
(
    input  logic [2:0]  mode,
    input  logic [15:0] cfg,
    input  frame_cls_t  cls,
    output logic        hit,
    output logic        mark
);
    logic l2_type_ok, l4_type_ok;
    assign l2_type_ok = {4'h0, cls.l2_msg} == cfg[15:8];
    assign l4_type_ok = {4'h0, cls.l4_msg} == cfg[15:8];

    always_comb begin
        case (mode)
            MODE_L2_V2:  hit = cls.l2_v2 && l2_type_ok;
            MODE_L4_V1:  hit = cls.l4_v1 && cls.v1_ctrl == cfg[7:0];
            MODE_ANY_V2: hit = (cls.l2_v2 && l2_type_ok) || (cls.l4_v2 && l4_type_ok);
            MODE_ALL:    hit = 1'b1;
            MODE_EVT_V2: hit = (cls.l2_v2 && is_event(cls.l2_msg)) ||
                               (cls.l4_v2 && is_event(cls.l4_msg));
            default:     hit = 1'b0;
        endcase
        mark = hit && mode != MODE_ALL;
    end
endmodule

// File: rtl/ptp_rx_latch.sv
module ptp_rx_latch
    import ptp_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              done,
    input  logic              hit,
    input  logic              mark,
    input  logic [TIME_W-1:0] frame_time,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              cap_valid,
    output logic              cap_en,
    output logic [2:0]        mode,
    output logic [15:0]       cfg,
    output logic [TIME_W-1:0] stamp,
    output logic              stat_valid,
    output logic              stat_ts
);
    logic take, hi_rd;
    assign take  = done && hit && cap_en && !cap_valid;
    assign hi_rd = reg_rd && reg_addr == ADDR_HI;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid  <= 1'b0;
            cap_en     <= 1'b0;
            mode       <= '0;
            cfg        <= '0;
            stamp      <= '0;
            stat_valid <= 1'b0;
            stat_ts    <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_CTL) begin
                cap_en <= reg_wdata[CTL_EN_BIT];
                mode   <= reg_wdata[CTL_MODE_LSB +: 3];
            end
            if (reg_wr && reg_addr == ADDR_CFG) cfg <= reg_wdata[15:0];
            // a lock still held at decision time refuses the frame
            if (take) begin
                stamp     <= frame_time;
                cap_valid <= 1'b1;
            end else if (hi_rd) begin
                cap_valid <= 1'b0;
            end
            stat_valid <= done;
            stat_ts    <= take && mark;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTL: begin
                reg_rdata[CTL_VALID_BIT]       = cap_valid;
                reg_rdata[CTL_MODE_LSB +: 3]   = mode;
                reg_rdata[CTL_EN_BIT]          = cap_en;
            end
            ADDR_CFG: reg_rdata[15:0] = cfg;
            ADDR_LO:  reg_rdata = stamp[REG_W-1:0];
            default:  reg_rdata = stamp[TIME_W-1:REG_W];
        endcase
    end
endmodule

// File: rtl/ptp_rx_stamp.sv
module ptp_rx_stamp
    import ptp_rx_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    input  logic [63:0] time_now,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        stat_valid,
    output logic [31:0] stat_word
);
    frame_cls_t        cls;
    logic              done, hit, mark, stat_ts;
    logic              cap_valid, cap_en;
    logic [2:0]        mode;
    logic [15:0]       cfg;
    logic [TIME_W-1:0] frame_time, stamp;

    ptp_rx_parser #(.IDX_W(IDX_W)) u_parser (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .time_now(time_now),
        .cls(cls), .done(done), .frame_time(frame_time)
    );

    ptp_rx_match u_match (
        .mode(mode), .cfg(cfg), .cls(cls), .hit(hit), .mark(mark)
    );

    ptp_rx_latch u_latch (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .done(done), .hit(hit),
        .mark(mark), .frame_time(frame_time), .reg_rdata(reg_rdata),
        .cap_valid(cap_valid), .cap_en(cap_en), .mode(mode), .cfg(cfg),
        .stamp(stamp), .stat_valid(stat_valid), .stat_ts(stat_ts)
    );

    assign stat_word = REG_W'(stat_ts) << STAT_TS_BIT;
endmodule

// File: rtl/ptp_rx_stamp_chk.sv
module ptp_rx_stamp_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic        stat_valid,
    input logic [31:0] stat_word,
    input logic        cap_valid,
    input logic        cap_en,
    input logic [63:0] stamp
);
    p_stamp_held_r10: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && $past(cap_valid)) |-> $stable(stamp));

    p_hi_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd3 && cap_valid) |=> !cap_valid);

    p_clash_unstamped_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd3 && cap_valid) |=> !stat_word[16]);

    p_capture_strobed_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_valid) |-> stat_valid);

    p_mark_in_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        stat_word[16] |-> stat_valid);

    p_disabled_r13: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !cap_valid) |=> !cap_valid);
endmodule

bind ptp_rx_stamp ptp_rx_stamp_chk u_chk (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .stat_valid(stat_valid), .stat_word(stat_word), .cap_valid(cap_valid),
    .cap_en(cap_en), .stamp(stamp)
);

// File: tb/ptp_rx_stamp_bench.sv
module ptp_rx_stamp_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 0, rx_sof = 0, rx_eof = 0;
    logic [7:0]  rx_data = 0;
    logic [63:0] time_now = 64'hA5A5_0000_0000_0100;
    logic        reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata, stat_word;
    logic        stat_valid;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0]  fb [0:127];
    logic [63:0] exp_t, prev_t;

    always #2 clk = ~clk;
    always @(posedge clk) time_now <= time_now + 64'h0000_0001_0000_0003;

    ptp_rx_stamp u_ptp_rx_stamp (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .time_now(time_now),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stat_valid(stat_valid), .stat_word(stat_word)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic setup(input logic en, input logic [2:0] mode, input logic [15:0] cfg);
        wr(2'd1, {16'h0, cfg});
        wr(2'd0, {27'h0, en, mode, 1'b0});
    endtask

    task automatic clr_fb();
        for (int i = 0; i < 128; i++) fb[i] = 8'h00;
        fb[12] = 8'h08; fb[13] = 8'h00; fb[14] = 8'h45; fb[23] = 8'h06;
    endtask

    task automatic mk_l2(input logic [3:0] msg, input logic [3:0] ver);
        clr_fb();
        fb[12] = 8'h88; fb[13] = 8'hF7; fb[14] = {4'h0, msg}; fb[15] = {4'h0, ver};
    endtask

    task automatic mk_l4(input logic [7:0] b42, input logic [7:0] b43, input logic [7:0] ctrl);
        clr_fb();
        fb[23] = 8'h11; fb[36] = 8'h01; fb[37] = 8'h3F;
        fb[42] = b42; fb[43] = b43; fb[74] = ctrl;
    endtask

    // returns at the negedge after the decision edge; optional high read in the decision cycle
    task automatic send(input int len, input bit clash);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = fb[i];
            if (i == 0) exp_t = time_now;
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        if (clash) begin reg_rd = 1; reg_addr = 2'd3; end
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic expect_stamp(input string req);
        logic [31:0] d;
        check({req, " strobe"}, 64'(stat_valid), 64'd1);
        check({req, " status bit16"}, 64'(stat_word), 64'h0001_0000);
        rd(2'd0, d); check({req, " valid set"}, 64'(d[0]), 64'd1);
        rd(2'd2, d); check({req, " R8 stamp low"}, 64'(d), 64'(exp_t[31:0]));
        rd(2'd3, d); check({req, " R8 stamp high"}, 64'(d), 64'(exp_t[63:32]));
        rd(2'd0, d); check({req, " R10 released"}, 64'(d[0]), 64'd0);
    endtask

    task automatic expect_none(input string req);
        logic [31:0] d;
        check({req, " strobe"}, 64'(stat_valid), 64'd1);
        check({req, " no status bit"}, 64'(stat_word), 64'd0);
        rd(2'd0, d); check({req, " valid clear"}, 64'(d[0]), 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        check("R1 strobe idle", 64'(stat_valid), 64'd0);
        check("R1 status word", 64'(stat_word), 64'd0);
        rd(2'd0, d); check("R1 control", 64'(d), 64'd0);
        rd(2'd1, d); check("R1 config", 64'(d), 64'd0);
        rd(2'd2, d); check("R1 stamp low", 64'(d), 64'd0);
        rd(2'd3, d); check("R1 stamp high", 64'(d), 64'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(2'd0, 32'h0000_001F);
        rd(2'd0, d); check("R2 control readback bit0 ignored", 64'(d), 64'h1E);
        wr(2'd1, 32'h0000_0D04);
        rd(2'd1, d); check("R2 config readback", 64'(d), 64'h0D04);
    endtask

    task automatic t_l2v2();
        setup(1, 3'b000, 16'h0100);
        mk_l2(4'd1, 4'd2); send(60, 0); expect_stamp("R3 match");
        mk_l2(4'd0, 4'd2); send(60, 0); expect_none("R3 other type");
        mk_l2(4'd1, 4'd1); send(60, 0); expect_none("R3 wrong version");
    endtask

    task automatic t_l4v1();
        setup(1, 3'b001, 16'h0000);
        mk_l4(8'h00, 8'h01, 8'h00); send(90, 0); expect_stamp("R4 match");
        mk_l4(8'h00, 8'h01, 8'h01); send(90, 0); expect_none("R4 other control");
    endtask

    task automatic t_anyv2();
        setup(1, 3'b010, 16'h0000);
        mk_l4(8'h00, 8'h02, 8'h00); send(60, 0); expect_stamp("R5 udp");
        mk_l2(4'd0, 4'd2); send(60, 0); expect_stamp("R5 layer2");
        mk_l4(8'h01, 8'h02, 8'h00); send(60, 0); expect_none("R5 other type");
    endtask

    task automatic t_evt();
        setup(1, 3'b101, 16'h0D00);
        mk_l2(4'd3, 4'd2); send(60, 0); expect_stamp("R6 layer2 event");
        mk_l4(8'h02, 8'h02, 8'h00); send(60, 0); expect_stamp("R6 udp event");
        mk_l4(8'h08, 8'h02, 8'h00); send(60, 0); expect_none("R6 general msg");
    endtask

    task automatic t_all();
        logic [31:0] d;
        setup(1, 3'b100, 16'h0000);
        clr_fb(); send(20, 0);
        check("R7 all strobe", 64'(stat_valid), 64'd1);
        check("R7 all no status bit", 64'(stat_word), 64'd0);
        rd(2'd0, d); check("R7 all captured", 64'(d[0]), 64'd1);
        rd(2'd2, d); check("R7 all stamp low", 64'(d), 64'(exp_t[31:0]));
        rd(2'd3, d);
        setup(1, 3'b011, 16'h0000);
        mk_l2(4'd0, 4'd2); send(60, 0); expect_none("R7 unused mode");
    endtask

    task automatic t_lock();
        logic [31:0] d;
        setup(1, 3'b000, 16'h0000);
        mk_l2(4'd0, 4'd2); send(60, 0);
        prev_t = exp_t;
        check("R10 first stamped", 64'(stat_word), 64'h0001_0000);
        rd(2'd2, d); check("R10 low read", 64'(d), 64'(prev_t[31:0]));
        rd(2'd0, d); check("R10 low read keeps valid", 64'(d[0]), 64'd1);
        send(60, 0);
        check("R10 locked frame unmarked", 64'(stat_word), 64'd0);
        rd(2'd2, d); check("R10 stamp held", 64'(d), 64'(prev_t[31:0]));
        rd(2'd3, d); check("R10 stamp high held", 64'(d), 64'(prev_t[63:32]));
        send(60, 0); expect_stamp("R10 after release");
    endtask

    task automatic t_clash();
        logic [31:0] d;
        setup(1, 3'b000, 16'h0000);
        mk_l2(4'd0, 4'd2); send(60, 0);
        prev_t = exp_t;
        send(60, 1);
        check("R11 clash frame unmarked", 64'(stat_word), 64'd0);
        rd(2'd0, d); check("R11 valid clear", 64'(d[0]), 64'd0);
        rd(2'd2, d); check("R11 stamp kept", 64'(d), 64'(prev_t[31:0]));
        send(60, 0); expect_stamp("R11 next frame");
    endtask

    task automatic t_short();
        setup(1, 3'b010, 16'h0000);
        mk_l2(4'd0, 4'd2); send(15, 0); expect_none("R12 layer2 short");
        send(16, 0); expect_stamp("R12 layer2 minimal");
        mk_l4(8'h00, 8'h02, 8'h00); send(43, 0); expect_none("R12 udp short");
        setup(1, 3'b001, 16'h0000);
        mk_l4(8'h00, 8'h01, 8'h00); send(74, 0); expect_none("R12 v1 short");
    endtask

    task automatic t_disable();
        setup(0, 3'b000, 16'h0000);
        mk_l2(4'd0, 4'd2); send(60, 0); expect_none("R13 disabled");
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_l2v2();
        t_l4v1();
        t_anyv2();
        t_evt();
        t_all();
        t_lock();
        t_clash();
        t_short();
        t_disable();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule